// File: doc/BRIEF.md
# Spill Bit-Level Hazard Checker

This block watches the decoded instructions of one instruction group, one per cycle, and reports illegal dependencies on a 64-bit collection register that holds the deferred-exception tag bits of spilled registers. Each instruction comes with a valid strobe, an operation class, a 6-bit index that selects one bit of the collection register, and its qualifying-predicate value. A spill store writes the selected bit. A fill load reads the selected bit. A move into the collection register writes the whole register, and a move out of it reads the whole register.

Dependencies between spills and fills are tracked bit by bit. Whole-register moves conflict with every bit. The block keeps a mask of the bits written so far in the group. Each instruction is checked against that mask. The first illegal pairing raises a registered violation flag and a kind code, and both hold until the group-end strobe arrives. The block does not decode instructions and does not model the data path.

Top module: `spill_hazard_chk`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the mask is cleared and after that edge `viol` is 0 and `viol_kind` is 2'b00.
- R2: Class encoding: 0 other, 1 fill, 2 spill, 3 move-in, 4 move-out. Spills to different bits in one group are legal. A spill to a bit that is already written in the group is a write-after-write violation, kind 2'b10.
- R3: A fill of a bit already written in the group by a spill is a read-after-write violation, kind 2'b01. A fill of an unwritten bit is legal.
- R4: A move-out after any spill or move-in in the same group is a read-after-write violation (2'b01).
- R5: A fill after a move-in in the same group is a read-after-write violation (2'b01), whatever its bit index.
- R6: A spill after a move-in, a move-in after a spill, and a second move-in in the same group are each a write-after-write violation (2'b10).
- R7: An instruction with `ins_pred` = 0 or `ins_valid` = 0 is neither checked nor recorded, so it cannot cause a violation now or later.
- R8: `viol` rises in the cycle after the offending instruction's edge and stays high until a group end.
- R9: The first violation of a group sets `viol_kind`. Later violations in the same group do not change it.
- R10: A `grp_end` clears the mask, `viol` and `viol_kind` at that edge. An instruction presented in the same cycle belongs to the new group and is recorded into the cleared mask.
- R11: Fills and move-outs record nothing. A spill after a fill or a move-out (write after read) is legal.
- R12: Class "other" neither records nor causes a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_class | input | 3 | Operation class (see R2) |
| ins_bit | input | 6 | Collection-register bit index used by a spill or fill |
| ins_pred | input | 1 | Qualifying-predicate value |
| grp_end | input | 1 | Closes the current group |
| viol | output | 1 | Violation seen in the current group |
| viol_kind | output | 2 | 01 read after write, 10 write after write, 00 none |

## Verification
The bench targets the bit granularity. A design that tracked the whole register would flag two spills to different bits, or a fill of an unwritten bit. It checks that squashed instructions leave no trace: a design that recorded a predicated-off spill would flag the next spill to that bit. It covers an instruction that arrives together with the group end, and a design that dropped it would miss the following same-bit spill. It also covers write-after-read orderings and first-wins kind retention, where a wrong design would flag a legal spill or overwrite 01 with 10.

// File: rtl/spill_haz_pkg.sv
// Shared types of the spill hazard checker: operation classes and violation kinds.
package spill_haz_pkg;
    typedef enum logic [2:0] {
        OP_OTHER    = 3'd0,
        OP_FILL     = 3'd1,
        OP_SPILL    = 3'd2,
        OP_MOVE_IN  = 3'd3,
        OP_MOVE_OUT = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_RAW  = 2'b01,
        KIND_WAW  = 2'b10
    } viol_kind_e;

    typedef struct packed {
        logic rd_bit;
        logic wr_bit;
        logic rd_all;
        logic wr_all;
    } access_t;
endpackage

// File: rtl/spill_haz_decode.sv
// Turns an instruction's class, valid and predicate into access intents on the
// collection register. Assumes one instruction per cycle. A squashed or absent
// instruction yields no access at all.
module spill_haz_decode
    import spill_haz_pkg::*;
(
    input  logic      ins_valid,
    input  logic      ins_pred,
    input  logic [2:0] ins_class,
    output access_t   acc
);
    logic live;

    // Purpose: an instruction takes part only when present and not predicated off.
    always_comb live = ins_valid & ins_pred;

    // Purpose: map the class to single-bit or whole-register reads and writes.
    always_comb begin
        acc = '0;
        if (live) begin
            case (ins_class)
                OP_FILL:     acc.rd_bit = 1'b1;
                OP_SPILL:    acc.wr_bit = 1'b1;
                OP_MOVE_IN:  acc.wr_all = 1'b1;
                OP_MOVE_OUT: acc.rd_all = 1'b1;
                default:     acc = '0;
            endcase
        end
    end
endmodule

// File: rtl/spill_haz_mask.sv
// Holds the written-bits mask of the current group. A single-bit write sets one
// bit and a whole-register write sets all of them. A clear empties the mask, and
// writes from the clearing cycle land in the emptied mask. Reports whether the
// selected bit or any bit is already written.
module spill_haz_mask #(
    parameter int NBITS = 64,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_bit,
    input  logic             wr_all,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_hit,
    output logic             any_hit
);
    logic [NBITS-1:0] written;

    for (genvar g = 0; g < NBITS; g++) begin : g_cell
        logic set_me;
        // Purpose: decide whether this cell is written this cycle.
        always_comb set_me = wr_all | (wr_bit && (idx == IDX_W'(g)));
        // Purpose: per-bit written flag, cleared by reset or group end.
        always_ff @(posedge clk) begin
            if (!rst_n)
                written[g] <= 1'b0;
            else if (clr)
                written[g] <= set_me;
            else if (set_me)
                written[g] <= 1'b1;
        end
    end

    // Purpose: lookups are blind during a clear, because the new group starts empty.
    always_comb begin
        bit_hit = !clr && written[idx];
        any_hit = !clr && (|written);
    end
endmodule

// File: rtl/spill_haz_flag.sv
// Turns access intents and mask hits into a hazard kind, and latches the first
// hazard of the group until a clear. Assumes at most one access per cycle.
module spill_haz_flag
    import spill_haz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  access_t    acc,
    input  logic       bit_hit,
    input  logic       any_hit,
    output logic       viol,
    output logic [1:0] viol_kind
);
    logic raw_now, waw_now;
    viol_kind_e kind_now;

    // Purpose: classify this cycle's access against what the group already wrote.
    always_comb begin
        raw_now  = (acc.rd_bit & bit_hit) | (acc.rd_all & any_hit);
        waw_now  = (acc.wr_bit & bit_hit) | (acc.wr_all & any_hit);
        kind_now = raw_now ? KIND_RAW : (waw_now ? KIND_WAW : KIND_NONE);
    end

    // Purpose: hold the first hazard of the group, and drop it at group end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            viol      <= 1'b0;
            viol_kind <= KIND_NONE;
        end else if (!viol && (kind_now != KIND_NONE)) begin
            viol      <= 1'b1;
            viol_kind <= kind_now;
        end
    end
endmodule

// File: rtl/spill_hazard_chk.sv
// Top of the spill hazard checker. It watches one instruction per cycle and
// flags read-after-write or write-after-write use of the collection register
// within a group, per bit for spills and fills and per register for moves.
module spill_hazard_chk
    import spill_haz_pkg::*;
#(
    parameter int NBITS = 64,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [2:0]       ins_class,
    input  logic [IDX_W-1:0] ins_bit,
    input  logic             ins_pred,
    input  logic             grp_end,
    output logic             viol,
    output logic [1:0]       viol_kind
);
    access_t acc;
    logic    bit_hit, any_hit;

    spill_haz_decode u_dec (
        .ins_valid (ins_valid),
        .ins_pred  (ins_pred),
        .ins_class (ins_class),
        .acc       (acc)
    );

    spill_haz_mask #(.NBITS(NBITS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (grp_end),
        .wr_bit  (acc.wr_bit),
        .wr_all  (acc.wr_all),
        .idx     (ins_bit),
        .bit_hit (bit_hit),
        .any_hit (any_hit)
    );

    spill_haz_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (grp_end),
        .acc       (acc),
        .bit_hit   (bit_hit),
        .any_hit   (any_hit),
        .viol      (viol),
        .viol_kind (viol_kind)
    );
endmodule

// File: rtl/spill_hazard_chk_sva.sv
// Checker for spill_hazard_chk, attached by bind. It sees only the ports.
module spill_hazard_chk_sva #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic [2:0]       ins_class,
    input logic [IDX_W-1:0] ins_bit,
    input logic             ins_pred,
    input logic             grp_end,
    input logic             viol,
    input logic [1:0]       viol_kind
);
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!viol && viol_kind == 2'b00));

    p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !grp_end) |=> viol);

    p_first_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !grp_end) |=> $stable(viol_kind));

    p_group_end_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end |=> (!viol && viol_kind == 2'b00));

    p_squashed_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol && !(ins_valid && ins_pred)) |=> !viol);

    p_other_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol && ins_class == 3'd0) |=> !viol);

    p_kind_coded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_kind == 2'b01 || viol_kind == 2'b10));
endmodule

bind spill_hazard_chk spill_hazard_chk_sva #(.IDX_W(IDX_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_class (ins_class),
    .ins_bit   (ins_bit),
    .ins_pred  (ins_pred),
    .grp_end   (grp_end),
    .viol      (viol),
    .viol_kind (viol_kind)
);

// File: tb/sim_spill_hazard_chk.sv
module sim_spill_hazard_chk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_valid = 1'b0;
    logic [2:0] ins_class = 3'd0;
    logic [5:0] ins_bit = 6'd0;
    logic       ins_pred = 1'b0;
    logic       grp_end = 1'b0;
    logic       viol;
    logic [1:0] viol_kind;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spill_hazard_chk u0 (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_class(ins_class),
        .ins_bit(ins_bit), .ins_pred(ins_pred), .grp_end(grp_end),
        .viol(viol), .viol_kind(viol_kind)
    );

    localparam int OT = 0, FL = 1, SP = 2, MI = 3, MO = 4;

    // Layout: [18:15] req, [14:12] class, [11:6] bit, [5] pred, [4] valid,
    // [3] group end, [2] expected viol, [1:0] expected kind.
    function automatic logic [18:0] v(int req, int cls, int b, int p, int vl,
                                      int e, int ev, int ek);
        v = {4'(req), 3'(cls), 6'(b), 1'(p), 1'(vl), 1'(e), 1'(ev), 2'(ek)};
    endfunction

    localparam int NV = 41;
    localparam logic [18:0] VEC [NV] = '{
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(2,  SP, 5, 1, 1, 0, 0, 0),   // R2 distinct bits legal
        v(2,  SP, 6, 1, 1, 0, 0, 0),
        v(3,  FL, 7, 1, 1, 0, 0, 0),   // R3 unwritten bit legal
        v(3,  FL, 5, 1, 1, 0, 1, 1),   // R3 fill after spill
        v(9,  SP, 5, 1, 1, 0, 1, 1),   // R9 later WAW keeps 01
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(2,  SP, 9, 1, 1, 0, 0, 0),
        v(2,  SP, 9, 1, 1, 0, 1, 2),   // R2 same bit twice
        v(9,  FL, 9, 1, 1, 0, 1, 2),   // R9 later RAW keeps 10
        v(10, SP, 3, 1, 1, 1, 0, 0),   // R10 instruction with group end
        v(10, SP, 3, 1, 1, 0, 1, 2),   // R10 it was recorded
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(11, FL, 4, 1, 1, 0, 0, 0),
        v(11, MO, 0, 1, 1, 0, 0, 0),
        v(11, SP, 4, 1, 1, 0, 0, 0),   // R11 write after read legal
        v(4,  MO, 0, 1, 1, 0, 1, 1),   // R4 move-out after spill
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(5,  MI, 0, 1, 1, 0, 0, 0),
        v(5,  FL, 33, 1, 1, 0, 1, 1),  // R5 fill after move-in
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(7,  SP, 63, 0, 1, 0, 0, 0),  // R7 squashed spill
        v(7,  SP, 63, 1, 1, 0, 0, 0),  // R7 not recorded
        v(7,  MI, 0, 0, 1, 0, 0, 0),   // R7 squashed move-in
        v(4,  MO, 0, 1, 1, 0, 1, 1),   // R4 move-out after spill
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(6,  SP, 0, 1, 1, 0, 0, 0),
        v(6,  MI, 0, 1, 1, 0, 1, 2),   // R6 move-in after spill
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(6,  MI, 0, 1, 1, 0, 0, 0),
        v(6,  SP, 12, 1, 1, 0, 1, 2),  // R6 spill after move-in
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(6,  MI, 0, 1, 1, 0, 0, 0),
        v(6,  MI, 0, 1, 1, 0, 1, 2),   // R6 two move-ins
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(12, OT, 0, 1, 1, 0, 0, 0),   // R12 other
        v(12, MO, 0, 1, 1, 0, 0, 0),   // R12 other recorded nothing
        v(10, OT, 0, 0, 0, 1, 0, 0),
        v(7,  SP, 1, 1, 0, 0, 0, 0),   // R7 invalid spill
        v(7,  SP, 1, 1, 1, 0, 0, 0),   // R7 not recorded
        v(10, OT, 0, 0, 0, 1, 0, 0)
    };

    task automatic check(int req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: {viol,kind} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(int cls, int b, bit p, bit vl, bit e);
        ins_class = 3'(cls); ins_bit = 6'(b); ins_pred = p;
        ins_valid = vl; grp_end = e;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        step();
        step();
        check(1, {viol, viol_kind}, 3'b000);           // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [18:0] e;
            e = VEC[i];
            drive(int'(e[14:12]), int'(e[11:6]), e[5], e[4], e[3]);
            step();
            check(int'(e[18:15]), {viol, viol_kind}, e[2:0]);
        end

        // R8: violation holds across idle cycles.
        drive(SP, 20, 1, 1, 0); step();
        drive(SP, 20, 1, 1, 0); step();
        check(8, {viol, viol_kind}, 3'b110);
        drive(OT, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            step();
            check(8, {viol, viol_kind}, 3'b110);
        end

        // R1: reset mid-group clears flag and mask.
        rst_n = 1'b0; step();
        check(1, {viol, viol_kind}, 3'b000);
        rst_n = 1'b1;
        drive(SP, 20, 1, 1, 0); step();
        check(1, {viol, viol_kind}, 3'b000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule